// File: doc/BRIEF.md
# Fourteen-Bit Mode Programmable Timer

This block is a 14-bit down counter. Each rising edge of an external timer input decrements it, once that input has been brought into the system clock domain. A host loads a count-length register one byte at a time. The register holds 14 count bits and 2 waveform-mode bits. A 2-bit command then starts or stops the counter.

The block drives a single timer output pin in one of four waveforms: a half-count low phase, a continuous square wave, a single low pulse, or a repeating low pulse. At each terminal count it latches a flag that the surrounding logic places in its status word. The host can read back the live count and the active mode bits as two bytes.

Address decode and status-word assembly are done by the surrounding logic. The block sees only write-enable, byte-select, command-strobe, status-read and read-select inputs.

Top module: `wave_timer14`

## Requirements
- R1: After reset the timer is idle. `tmr_out` is 1, `tc_flag` is 0, both read bytes are 0 and the length register holds 0.
- R2: A write with `wr_hi`=0 loads length bits 7:0 from `wr_data`. A write with `wr_hi`=1 loads length bits 13:8 from `wr_data[5:0]` and the mode from `wr_data[7:6]`.
- R3: With `rd_hi`=0, `rd_data` is the live count bits 7:0. With `rd_hi`=1, it is {active mode, live count bits 13:8}.
- R4: START (`cmd`=11) while idle loads the count and mode from the length register and begins counting. Each timer-input rising edge lowers the count by one. The edge taken while the count is 1 is the terminal count.
- R5: Mode 01 gives a square wave. The output is high while count > floor(L/2), so an odd L has the longer half high (L=9: 5 high, 4 low). At terminal count the counter reloads L, for a period of L input edges.
- R6: Mode 00 gives the same high-then-low shape for one period only. At terminal count the counter stops with count 0 and the output high.
- R7: Mode 10 drives the output low for the one input period in which the count is 1. At terminal count the counter stops with count 0 and the output returns high.
- R8: Mode 11 drives the same one-period low pulse in every period and reloads L at each terminal count.
- R9: STOP (`cmd`=01) halts a running counter at once. The count is frozen and the output goes high. When the timer is idle, STOP has no effect. NOP (`cmd`=00) never has an effect.
- R10: STOP-AFTER-TC (`cmd`=10) lets a running counter reach its next terminal count, then stops it with count 0. When the timer is idle it has no effect.
- R11: START while running changes nothing at once. At the next terminal count the counter reloads from the length register's current length and mode, and keeps running.
- R12: `tc_flag` is set at each terminal count. A `status_rd` pulse clears it, and so does a START that begins counting from idle.
- R13: A programmed length of 0 or 1 is handled as 2.
- R14: Writes to the length register do not change a running count or mode until a START takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_in | input | 1 | Asynchronous timer input; rising edges are counted |
| wr_en | input | 1 | Write strobe for the length register |
| wr_hi | input | 1 | Byte select for writes: 0 low byte, 1 high byte |
| wr_data | input | 8 | Write data byte |
| cmd_valid | input | 1 | One-cycle strobe for `cmd` |
| cmd | input | 2 | 00 NOP, 01 STOP, 10 STOP-AFTER-TC, 11 START |
| status_rd | input | 1 | One-cycle pulse: status word was read, clear flag |
| rd_hi | input | 1 | Read byte select |
| rd_data | output | 8 | Live count / mode byte |
| tmr_out | output | 1 | Timer waveform output |
| tc_flag | output | 1 | Latched terminal-count flag |

## Verification
A timer-input rising edge passes two synchroniser stages and an edge register. The count therefore changes on the third clock edge after the input rises, and `tmr_out` follows one clock later. Commands, length writes and status reads act on the clock edge that samples them, and the registered output again trails by one clock. The bench holds the timer input high for six clocks and low for six more. It drives commands and writes between input edges, and samples every output at a falling clock edge at least two clocks after its last stimulus, so every result has settled.

// File: rtl/tmr14_pkg.sv
// Shared definitions for the 14-bit mode timer.
// Assumes: command encoding is fixed by the host's command byte layout.
package tmr14_pkg;
    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_STOP    = 2'b01,
        CMD_STOP_TC = 2'b10,
        CMD_START   = 2'b11
    } tmr_cmd_e;

    localparam int MODE_W = 2;
endpackage

// File: rtl/tmr14_sync_edge.sv
// Synchronises the asynchronous timer input and emits a one-clock tick on
// each rising edge. Assumes the input stays high and low for at least
// STAGES+1 clocks each.
module tmr14_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic tick
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // shift the input through the synchroniser chain and remember the last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign tick = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr14_len_reg.sv
// Count-length register written as two bytes: low byte carries count bits
// 7:0, high byte carries the mode in 7:6 and the upper count bits below.
// Assumes CNT_W is between 9 and 14 so the upper bits fit under the mode.
module tmr14_len_reg #(
    parameter int CNT_W = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_hi,
    input  logic [7:0]                wr_data,
    output logic [CNT_W-1:0]          len_q,
    output logic [tmr14_pkg::MODE_W-1:0] mode_q
);
    localparam int HI_W = CNT_W - 8;

    // capture the selected byte of the length register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            if (wr_hi) begin
                len_q[CNT_W-1:8] <= wr_data[HI_W-1:0];
                mode_q           <= wr_data[7:6];
            end else begin
                len_q[7:0] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/tmr14_core.sv
// Counter core: start/stop command handling, down counting, terminal count,
// reload, deferred start and the latched terminal-count flag.
// Assumes tick is a single-clock pulse; lengths below 2 are raised to 2.
module tmr14_core #(
    parameter int CNT_W = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd,
    input  logic                         status_rd,
    input  logic [CNT_W-1:0]             clr_len,
    input  logic [tmr14_pkg::MODE_W-1:0] clr_mode,
    output logic [CNT_W-1:0]             count_q,
    output logic [CNT_W-1:0]             act_len_q,
    output logic [tmr14_pkg::MODE_W-1:0] act_mode_q,
    output logic                         running_q,
    output logic                         start_pend_q,
    output logic                         stop_pend_q,
    output logic                         flag_q
);
    import tmr14_pkg::*;

    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] load_len;
    logic             stop_now;
    logic             start_idle;
    logic             at_tc;
    logic             repeat_mode;

    // derive command decodes and the clamped reload value
    always_comb begin
        load_len    = (clr_len < MIN_LEN) ? MIN_LEN : clr_len;
        stop_now    = cmd_valid && (cmd == CMD_STOP);
        start_idle  = cmd_valid && (cmd == CMD_START) && !running_q;
        at_tc       = running_q && tick && (count_q == ONE) && !stop_now;
        repeat_mode = act_mode_q[0];
    end

    // advance the counter state and its pending-command flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q      <= '0;
            act_len_q    <= '0;
            act_mode_q   <= '0;
            running_q    <= 1'b0;
            start_pend_q <= 1'b0;
            stop_pend_q  <= 1'b0;
        end else begin
            if (cmd_valid && running_q) begin
                case (cmd)
                    CMD_STOP: begin
                        running_q    <= 1'b0;
                        start_pend_q <= 1'b0;
                        stop_pend_q  <= 1'b0;
                    end
                    CMD_STOP_TC: begin
                        stop_pend_q  <= 1'b1;
                        start_pend_q <= 1'b0;
                    end
                    CMD_START: begin
                        start_pend_q <= 1'b1;
                        stop_pend_q  <= 1'b0;
                    end
                    default: ;
                endcase
            end else if (start_idle) begin
                count_q      <= load_len;
                act_len_q    <= load_len;
                act_mode_q   <= clr_mode;
                running_q    <= 1'b1;
                start_pend_q <= 1'b0;
                stop_pend_q  <= 1'b0;
            end

            if (running_q && tick && !stop_now) begin
                if (count_q == ONE) begin
                    if (start_pend_q) begin
                        count_q    <= load_len;
                        act_len_q  <= load_len;
                        act_mode_q <= clr_mode;
                    end else if (stop_pend_q || !repeat_mode) begin
                        count_q   <= '0;
                        running_q <= 1'b0;
                    end else begin
                        count_q <= act_len_q;
                    end
                    start_pend_q <= 1'b0;
                    stop_pend_q  <= 1'b0;
                end else begin
                    count_q <= count_q - ONE;
                end
            end
        end
    end

    // latch the terminal-count flag; a new terminal count beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (at_tc) begin
            flag_q <= 1'b1;
        end else if (status_rd || start_idle) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr14_wave.sv
// Registered waveform generator. Bit 1 of the mode selects pulse shape
// (low while count is 1) versus half-count shape (high while count is above
// half the length). Assumes the output idles high.
module tmr14_wave #(
    parameter int CNT_W = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         running,
    input  logic [CNT_W-1:0]             count,
    input  logic [CNT_W-1:0]             act_len,
    input  logic [tmr14_pkg::MODE_W-1:0] act_mode,
    output logic                         out_q
);
    logic [CNT_W-1:0] half_len;
    logic             wave;

    // choose the level for the present count
    always_comb begin
        half_len = act_len >> 1;
        if (act_mode[1]) begin
            wave = (count != CNT_W'(1));
        end else begin
            wave = (count > half_len);
        end
    end

    // register the pin level, high whenever the counter is idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else begin
            out_q <= running ? wave : 1'b1;
        end
    end
endmodule

// File: rtl/wave_timer14.sv
// Top of the 14-bit mode timer: input synchroniser, length register,
// counter core, waveform generator and the count/mode read mux.
// Assumes CNT_W + MODE_W equals 16 so the read-back fills two bytes.
module wave_timer14 #(
    parameter int CNT_W       = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tmr_in,
    input  logic       wr_en,
    input  logic       wr_hi,
    input  logic [7:0] wr_data,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic       status_rd,
    input  logic       rd_hi,
    output logic [7:0] rd_data,
    output logic       tmr_out,
    output logic       tc_flag
);
    import tmr14_pkg::*;

    logic                   tick;
    logic [CNT_W-1:0]       clr_len;
    logic [MODE_W-1:0]      clr_mode;
    logic [CNT_W-1:0]       count;
    logic [CNT_W-1:0]       act_len;
    logic [MODE_W-1:0]      act_mode;
    logic                   running;
    logic                   start_pend;
    logic                   stop_pend;

    tmr14_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(tmr_in), .tick(tick)
    );

    tmr14_len_reg #(.CNT_W(CNT_W)) u_len (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_data(wr_data), .len_q(clr_len), .mode_q(clr_mode)
    );

    tmr14_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd(cmd), .status_rd(status_rd), .clr_len(clr_len),
        .clr_mode(clr_mode), .count_q(count), .act_len_q(act_len),
        .act_mode_q(act_mode), .running_q(running),
        .start_pend_q(start_pend), .stop_pend_q(stop_pend), .flag_q(tc_flag)
    );

    tmr14_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .running(running), .count(count),
        .act_len(act_len), .act_mode(act_mode), .out_q(tmr_out)
    );

    // select the live count byte or the mode plus upper count bits
    always_comb begin
        rd_data = rd_hi ? {act_mode, count[CNT_W-1:8]} : count[7:0];
    end
endmodule

// File: rtl/wave_timer14_chk.sv
// Assertion checker for the 14-bit mode timer, bound to the top module.
// Assumes synchronous active-low reset and single-clock command strobes.
module wave_timer14_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cmd_valid,
    input logic             status_rd,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic             tc_flag,
    input logic             tmr_out,
    input logic             start_pend,
    input logic             stop_pend
);
    // R12
    flag_set_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_flag) |-> $past(running && tick && count == CNT_W'(1)));

    // R12
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !(running && tick)) |=> !tc_flag);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cmd_valid) |=> ($stable(count) && !running));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && count > CNT_W'(1) && !cmd_valid)
        |=> (count == $past(count) - CNT_W'(1)));

    // R1
    out_low_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_out |-> $past(running));

    // R11
    pend_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pend, stop_pend}));

    // R10
    stop_pend_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pend |-> running);
endmodule

bind wave_timer14 wave_timer14_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .status_rd(status_rd), .running(running), .count(count),
    .tc_flag(tc_flag), .tmr_out(tmr_out), .start_pend(start_pend),
    .stop_pend(stop_pend)
);

// File: tb/tb_wave_timer14.sv
module tb_wave_timer14;
    localparam int CLK_PERIOD = 10;
    localparam int TIN_HALF   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_in = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd = '0;
    logic       status_rd = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] rd_data;
    logic       tmr_out;
    logic       tc_flag;

    wave_timer14 dut (
        .clk(clk), .rst_n(rst_n), .tmr_in(tmr_in), .wr_en(wr_en),
        .wr_hi(wr_hi), .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd(cmd),
        .status_rd(status_rd), .rd_hi(rd_hi), .rd_data(rd_data),
        .tmr_out(tmr_out), .tc_flag(tc_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state, updated from the requirements
    int m_run, m_cnt, m_len, m_mode, m_sp, m_tp, m_flag, m_clr_len, m_clr_mode;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic int eff_len(int l);
        return (l < 2) ? 2 : l;
    endfunction

    function automatic int exp_out();
        if (m_run == 0) return 1;
        if ((m_mode & 2) != 0) return (m_cnt != 1) ? 1 : 0;
        return (m_cnt > (m_len / 2)) ? 1 : 0;
    endfunction

    function automatic string mode_tag();
        case (m_mode)
            0: return "R6";
            1: return "R5";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state(string cnt_tag, string out_tag);
        logic [7:0] lo;
        logic [7:0] hi;
        @(negedge clk);
        rd_hi = 1'b0; #1; lo = rd_data;
        rd_hi = 1'b1; #1; hi = rd_data;
        chk(cnt_tag, int'({hi[5:0], lo}), m_cnt);
        chk("R3", int'(hi[7:6]), m_mode);
        chk(out_tag, int'(tmr_out), exp_out());
        chk("R12", int'(tc_flag), m_flag);
    endtask

    task automatic load_active();
        m_len = eff_len(m_clr_len);
        m_cnt = m_len;
        m_mode = m_clr_mode;
    endtask

    task automatic wr_clr(int len, int mode);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = 1'b0; wr_data = len[7:0];
        @(negedge clk);
        wr_hi = 1'b1; wr_data = {mode[1:0], len[13:8]};
        @(negedge clk);
        wr_en = 1'b0; wr_hi = 1'b0;
        m_clr_len = len & 16'h3fff;
        m_clr_mode = mode & 3;
    endtask

    task automatic send_cmd(int c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c[1:0];
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 2'b00;
        if (m_run != 0) begin
            case (c)
                1: begin m_run = 0; m_sp = 0; m_tp = 0; end
                2: begin m_tp = 1; m_sp = 0; end
                3: begin m_sp = 1; m_tp = 0; end
                default: ;
            endcase
        end else if (c == 3) begin
            load_active();
            m_run = 1; m_flag = 0; m_sp = 0; m_tp = 0;
        end
        @(negedge clk);
    endtask

    task automatic stat_rd();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        m_flag = 0;
    endtask

    task automatic tin_tick();
        @(negedge clk);
        tmr_in = 1'b1;
        repeat (TIN_HALF) @(negedge clk);
        tmr_in = 1'b0;
        repeat (TIN_HALF - 1) @(negedge clk);
        if (m_run != 0) begin
            if (m_cnt == 1) begin
                m_flag = 1;
                if (m_sp != 0) begin
                    load_active();
                end else if (m_tp != 0 || (m_mode & 1) == 0) begin
                    m_cnt = 0; m_run = 0;
                end else begin
                    m_cnt = m_len;
                end
                m_sp = 0; m_tp = 0;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int highs;
        void'($urandom(32'd2024));
        m_run = 0; m_cnt = 0; m_len = 0; m_mode = 0; m_sp = 0; m_tp = 0;
        m_flag = 0; m_clr_len = 0; m_clr_mode = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_state("R1", "R1");

        // R2 byte writes, R5 square wave with odd length 9
        wr_clr(9, 1);
        check_state("R2", "R5");
        send_cmd(3);
        check_state("R2", "R5");
        highs = 0;
        for (int i = 0; i < 9; i++) begin
            tin_tick();
            check_state("R4", "R5");
            highs += int'(tmr_out);
        end
        chk("R5", highs, 5);
        for (int i = 0; i < 4; i++) begin tin_tick(); check_state("R4", "R5"); end

        // R9 immediate stop freezes count, then ignored when idle
        send_cmd(1);
        check_state("R9", "R9");
        tin_tick();
        check_state("R9", "R9");
        send_cmd(1);
        check_state("R9", "R9");
        send_cmd(0);
        check_state("R9", "R9");

        // R12 status read clears the flag
        stat_rd();
        check_state("R12", "R12");

        // R8 repeating pulse, then R10 stop after terminal count
        wr_clr(3, 3);
        send_cmd(3);
        check_state("R4", "R8");
        for (int i = 0; i < 7; i++) begin tin_tick(); check_state("R4", "R8"); end
        send_cmd(2);
        check_state("R10", "R10");
        for (int i = 0; i < 4; i++) begin tin_tick(); check_state("R10", "R10"); end
        chk("R10", m_run, 0);
        send_cmd(2);
        check_state("R10", "R10");

        // R7 single pulse
        wr_clr(4, 2);
        send_cmd(3);
        for (int i = 0; i < 6; i++) begin tin_tick(); check_state("R4", "R7"); end

        // R6 one period with low second half
        wr_clr(5, 0);
        send_cmd(3);
        for (int i = 0; i < 7; i++) begin tin_tick(); check_state("R4", "R6"); end

        // R13 short lengths are raised to 2
        wr_clr(1, 1);
        send_cmd(3);
        check_state("R13", "R13");
        tin_tick(); check_state("R13", "R13");
        tin_tick(); check_state("R13", "R13");
        send_cmd(1);
        wr_clr(0, 1);
        send_cmd(3);
        check_state("R13", "R13");
        send_cmd(1);

        // R14 writes do not disturb a running count; R11 deferred start
        wr_clr(6, 1);
        send_cmd(3);
        tin_tick();
        wr_clr(3, 3);
        check_state("R14", "R14");
        send_cmd(3);
        check_state("R11", "R11");
        for (int i = 0; i < 10; i++) begin tin_tick(); check_state("R11", "R11"); end
        send_cmd(1);
        stat_rd();

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 11);
            if (r < 6) tin_tick();
            else if (r == 6) send_cmd($urandom_range(0, 3));
            else if (r == 7) wr_clr($urandom_range(0, 12), $urandom_range(0, 3));
            else if (r == 8) stat_rd();
            else if (r == 9) send_cmd(3);
            else if (r == 10) send_cmd(2);
            else tin_tick();
            check_state("R4", mode_tag());
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule